// File: doc/BRIEF.md
# Iterative Integer Divider with Interrupt Cancellation

This block is a multi-cycle integer divider meant to sit beside the execute stage of a simple in-order processor. One request carries a dividend, a divisor and a flag that selects two's-complement or unsigned arithmetic. The block returns the quotient and the remainder together. It uses a start/busy/done handshake, and every operation has the same fixed latency.

Internally it runs a restoring divider that retires two quotient bits per cycle. Signed operands are turned into magnitudes on entry, and the signs are put back on exit. Any cycles left over inside the fixed latency are spent waiting before the result is published.

Interrupt latency must stay bounded, so an interrupt-pending input cancels a running operation on the very next clock edge. The block then pulses an aborted flag and leaves its result outputs untouched. The instruction is expected to be issued again later.

Top module: `iterDivider`

## Requirements
- R1: For unsigned requests (isSigned = 0), quotient and remainder are the integer quotient and remainder of dividend by divisor, both read as unsigned 32-bit values.
- R2: For signed requests (isSigned = 1, two's complement), the quotient is truncated toward zero and a nonzero remainder carries the sign of the dividend.
- R3: A request is accepted on a rising edge where start is 1, busy is 0 and irqPending is 0. From the next cycle busy is 1. done is a single-cycle pulse that appears right after the 19th rising edge following the accepting edge. busy falls at that same edge.
- R4: A zero divisor completes with the normal latency and returns a quotient of all ones and a remainder equal to the dividend, for both signed and unsigned requests.
- R5: A signed request of 0x80000000 divided by 0xFFFFFFFF returns quotient 0x80000000 and remainder 0.
- R6: If irqPending is 1 on any rising edge while busy is 1, then on that edge busy falls and aborted becomes a one-cycle pulse. No done follows for that request, and quotient and remainder keep their previous values. This holds on the edge that would otherwise have completed the request.
- R7: A start while busy is 1 is ignored. The running request completes at its original time with its original result.
- R8: A start while idle with irqPending at 1 is not accepted: busy stays 0 and no done or aborted follows.
- R9: After reset, busy, done and aborted are 0 and quotient and remainder are 0.
- R10: quotient and remainder change only at the edge that raises done, and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a division |
| isSigned | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend | input | 32 | Dividend, sampled on the accepting edge |
| divisor | input | 32 | Divisor, sampled on the accepting edge |
| irqPending | input | 1 | Interrupt pending; cancels a running division |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse: result is valid |
| aborted | output | 1 | One-cycle pulse: running division was cancelled |
| quotient | output | 32 | Quotient of the last completed division |
| remainder | output | 32 | Remainder of the last completed division |

## Verification
The bench builds the block with its default parameters: a 32-bit width, two quotient bits per iteration and a 19-cycle latency. With these values the 16 iterations leave three cycles of slack in the latency. That brings two cases within reach: an abort arriving after the iteration has finished but before the result is published, and an abort on the completing edge itself. Full 32-bit operands also reach the signed corner values 0x80000000 and 0xFFFFFFFF, the all-ones dividend and the zero divisor.

// File: rtl/divPkg.sv
package divPkg;
  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic load;     // capture operands
    logic iterate;  // retire STEP_BITS quotient bits
    logic finish;   // publish signed result
  } divStrobes_t;
endpackage

// File: rtl/divCtrl.sv
module divCtrl
  import divPkg::*;
#(
  parameter int LATENCY = 19,
  parameter int ITERS   = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        irqPending,
  output logic        busy,
  output logic        done,
  output logic        aborted,
  output divStrobes_t strobes
);
  localparam int CW = $clog2(LATENCY + 1);

  logic [CW-1:0] cycleCnt;
  logic accept, cancel, last;

  assign accept = start && !busy && !irqPending;
  assign cancel = busy && irqPending;
  assign last   = busy && !irqPending && (cycleCnt == CW'(LATENCY - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      aborted  <= 1'b0;
      cycleCnt <= '0;
    end else begin
      done    <= last;
      aborted <= cancel;
      if (accept) begin
        busy     <= 1'b1;
        cycleCnt <= '0;
      end else if (cancel || last) begin
        busy <= 1'b0;
      end else if (busy) begin
        cycleCnt <= cycleCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.load    = accept;
    strobes.iterate = busy && !irqPending && (cycleCnt < CW'(ITERS));
    strobes.finish  = last;
  end

  initial assert (LATENCY >= ITERS + 1) else $error("LATENCY too short for ITERS");

  // R3: the counter never runs past the latency window
  assert_cnt_in_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (cycleCnt < CW'(LATENCY)));
  // R3: done is a single-cycle pulse and busy is already low with it
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_done_not_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R6: aborted only follows a busy cycle with an interrupt pending
  assert_abort_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(aborted) |-> ($past(busy) && $past(irqPending)));
  assert_abort_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(aborted && done));
  // R7: a start while busy does not restart the count
  assert_busy_ignores_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !irqPending && !last) |=> (busy && cycleCnt == $past(cycleCnt) + 1'b1));
endmodule

// File: rtl/divDatapath.sv
module divDatapath
  import divPkg::*;
#(
  parameter int WIDTH     = 32,
  parameter int STEP_BITS = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  divStrobes_t      strobes,
  input  logic             isSigned,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);
  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] divisorMag, partRem, acc, origDividend;
  logic             negQuo, negRem, zeroDiv, ovfCase;
  logic [WIDTH-1:0] nextRem, nextAcc;
  logic             sgnA, sgnB;

  assign sgnA = isSigned && dividend[WIDTH-1];
  assign sgnB = isSigned && divisor[WIDTH-1];

  // STEP_BITS restoring steps per cycle
  always_comb begin
    logic [WIDTH:0]   r;
    logic [WIDTH:0]   trial;
    logic [WIDTH-1:0] a;
    r = {1'b0, partRem};
    a = acc;
    for (int s = 0; s < STEP_BITS; s++) begin
      r     = {r[WIDTH-1:0], a[WIDTH-1]};
      a     = {a[WIDTH-2:0], 1'b0};
      trial = r - {1'b0, divisorMag};
      if (!trial[WIDTH]) begin
        r    = trial;
        a[0] = 1'b1;
      end
    end
    nextRem = r[WIDTH-1:0];
    nextAcc = a;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divisorMag   <= '0;
      partRem      <= '0;
      acc          <= '0;
      origDividend <= '0;
      negQuo       <= 1'b0;
      negRem       <= 1'b0;
      zeroDiv      <= 1'b0;
      ovfCase      <= 1'b0;
      quotient     <= '0;
      remainder    <= '0;
    end else begin
      if (strobes.load) begin
        acc          <= sgnA ? -dividend : dividend;
        divisorMag   <= sgnB ? -divisor : divisor;
        partRem      <= '0;
        origDividend <= dividend;
        negQuo       <= sgnA ^ sgnB;
        negRem       <= sgnA;
        zeroDiv      <= (divisor == '0);
        ovfCase      <= isSigned && (dividend == MOST_NEG) && (divisor == '1);
      end else if (strobes.iterate) begin
        acc     <= nextAcc;
        partRem <= nextRem;
      end
      if (strobes.finish) begin
        quotient  <= zeroDiv ? '1 : (negQuo ? -acc : acc);
        remainder <= zeroDiv ? origDividend : (negRem ? -partRem : partRem);
      end
    end
  end

  // R10: results move only when the control publishes
  assert_hold_result_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.finish) |-> ($stable(quotient) && $stable(remainder)));
  // R5: most-negative over minus one wraps to most-negative, remainder zero
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.finish && ovfCase) |=> (quotient == MOST_NEG && remainder == '0));
  // R1: partial remainder stays below the divisor while iterating
  assert_rem_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.finish && !zeroDiv) |-> (partRem < divisorMag));
endmodule

// File: rtl/iterDivider.sv
module iterDivider
  import divPkg::*;
#(
  parameter int WIDTH     = 32,
  parameter int STEP_BITS = 2,
  parameter int LATENCY   = 19
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             isSigned,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  input  logic             irqPending,
  output logic             busy,
  output logic             done,
  output logic             aborted,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);
  localparam int ITERS = WIDTH / STEP_BITS;

  divStrobes_t strobes;

  divCtrl #(.LATENCY(LATENCY), .ITERS(ITERS)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .irqPending(irqPending),
    .busy(busy), .done(done), .aborted(aborted), .strobes(strobes)
  );

  divDatapath #(.WIDTH(WIDTH), .STEP_BITS(STEP_BITS)) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .isSigned(isSigned),
    .dividend(dividend), .divisor(divisor),
    .quotient(quotient), .remainder(remainder)
  );
endmodule

// File: tb/tb_iterDivider.sv
module tb_iterDivider;
  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic        s;
    logic [31:0] q;
    logic [31:0] r;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{32'd100,        32'd7,          1'b0, 32'd14,         32'd2},          // R1
    '{32'hFFFFFFFF,   32'd1,          1'b0, 32'hFFFFFFFF,   32'd0},          // R1
    '{32'hFFFFFFFF,   32'h10,         1'b0, 32'h0FFFFFFF,   32'hF},          // R1
    '{32'd3,          32'd5,          1'b0, 32'd0,          32'd3},          // R1
    '{32'd1000000,    32'd1000,       1'b0, 32'd1000,       32'd0},          // R1
    '{32'h80000000,   32'hFFFFFFFF,   1'b0, 32'd0,          32'h80000000},   // R1
    '{32'hFFFFFFF9,   32'd2,          1'b1, 32'hFFFFFFFD,   32'hFFFFFFFF},   // R2
    '{32'd7,          32'hFFFFFFFE,   1'b1, 32'hFFFFFFFD,   32'd1},          // R2
    '{32'hFFFFFFF9,   32'hFFFFFFFE,   1'b1, 32'd3,          32'hFFFFFFFF},   // R2
    '{32'hFFFFFF9C,   32'd7,          1'b1, 32'hFFFFFFF2,   32'hFFFFFFFE},   // R2
    '{32'h80000000,   32'hFFFFFFFF,   1'b1, 32'h80000000,   32'd0},          // R5
    '{32'd12345,      32'd0,          1'b0, 32'hFFFFFFFF,   32'd12345},      // R4
    '{32'hFFFFFFFB,   32'd0,          1'b1, 32'hFFFFFFFF,   32'hFFFFFFFB}    // R4
  };
  localparam int LAT = 19;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, isSigned = 1'b0, irqPending = 1'b0;
  logic [31:0] dividend = '0, divisor = '0;
  logic busy, done, aborted;
  logic [31:0] quotient, remainder;
  int nChecks = 0, nFails = 0, cycles = 0;

  always #2 clk = ~clk;  // 250 MHz

  iterDivider dut (
    .clk(clk), .rstN(rstN), .start(start), .isSigned(isSigned),
    .dividend(dividend), .divisor(divisor), .irqPending(irqPending),
    .busy(busy), .done(done), .aborted(aborted),
    .quotient(quotient), .remainder(remainder)
  );

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Issue a request at the next negedge; returns after the accepting edge (at negedge)
  task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic s);
    @(negedge clk);
    dividend = a; divisor = b; isSigned = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Wait out the latency, checking timing; returns at negedge after done
  task automatic waitDone(input string req);
    logic early = 1'b0;
    for (int i = 1; i < LAT; i++) begin
      @(negedge clk);
      if (done || !busy) early = 1'b1;
    end
    @(negedge clk);
    check(req, "no early done / busy held", {63'd0, early}, 64'd0);
    check(req, "done,busy at latency", {62'd0, done, busy}, {62'd0, 1'b1, 1'b0});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] keepQ, keepR;
    logic seen;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", "busy/done/aborted", {61'd0, busy, done, aborted}, 64'd0);
    check("R9", "outputs", {quotient, remainder}, 64'd0);
    rstN = 1'b1;

    // Vector table: R1 R2 R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      issue(VECS[v].a, VECS[v].b, VECS[v].s);
      check("R3", "busy after accept", {63'd0, busy}, 64'd1);
      waitDone("R3");
      check(VECS[v].s ? "R2" : "R1", $sformatf("vector %0d q,r", v),
            {quotient, remainder}, {VECS[v].q, VECS[v].r});
      @(negedge clk);
      check("R3", "done one cycle", {63'd0, done}, 64'd0);
      check("R10", "result held", {quotient, remainder}, {VECS[v].q, VECS[v].r});
    end

    // R7: start while busy ignored
    issue(32'd50, 32'd6, 1'b0);
    repeat (4) @(negedge clk);
    dividend = 32'd999; divisor = 32'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 6; i < LAT; i++) @(negedge clk);
    @(negedge clk);
    check("R7", "completes on original schedule", {63'd0, done}, 64'd1);
    check("R7", "original result", {quotient, remainder}, {32'd8, 32'd2});
    @(negedge clk);
    check("R7", "no restart", {62'd0, busy, done}, 64'd0);

    // R6: abort mid-iteration
    keepQ = quotient; keepR = remainder;
    issue(32'd77, 32'd3, 1'b0);
    repeat (4) @(negedge clk);
    irqPending = 1'b1;
    @(negedge clk);
    irqPending = 1'b0;
    check("R6", "aborted pulse, busy low", {62'd0, aborted, busy}, {62'd0, 1'b1, 1'b0});
    @(negedge clk);
    check("R6", "aborted one cycle", {63'd0, aborted}, 64'd0);
    seen = 1'b0;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      if (done || busy) seen = 1'b1;
    end
    check("R6", "no done after abort", {63'd0, seen}, 64'd0);
    check("R6", "outputs unchanged", {quotient, remainder}, {keepQ, keepR});

    // R6: abort in the slack after iteration (edge 18)
    issue(32'd77, 32'd3, 1'b0);
    for (int i = 1; i < LAT - 1; i++) @(negedge clk);
    irqPending = 1'b1;
    @(negedge clk);
    irqPending = 1'b0;
    check("R6", "late abort pulse", {62'd0, aborted, busy}, {62'd0, 1'b1, 1'b0});
    check("R6", "late abort outputs", {quotient, remainder}, {keepQ, keepR});

    // R6: abort on the completing edge wins
    issue(32'd77, 32'd3, 1'b0);
    for (int i = 1; i < LAT; i++) @(negedge clk);
    irqPending = 1'b1;
    @(negedge clk);
    irqPending = 1'b0;
    check("R6", "abort beats done", {62'd0, aborted, done}, {62'd0, 1'b1, 1'b0});
    check("R6", "abort-on-last outputs", {quotient, remainder}, {keepQ, keepR});

    // R8: start with interrupt pending while idle
    @(negedge clk);
    irqPending = 1'b1; dividend = 32'd9; divisor = 32'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0; irqPending = 1'b0;
    check("R8", "not accepted", {63'd0, busy}, 64'd0);
    seen = 1'b0;
    for (int i = 0; i < LAT + 2; i++) begin
      @(negedge clk);
      if (done || aborted || busy) seen = 1'b1;
    end
    check("R8", "no activity", {63'd0, seen}, 64'd0);

    // Reissue after abort succeeds (R1)
    issue(32'd77, 32'd3, 1'b0);
    waitDone("R3");
    check("R1", "reissued result", {quotient, remainder}, {32'd25, 32'd2});

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule